// File: doc/BRIEF.md
# Operand Forwarding and Load-Use Hazard Unit

This combinational unit sits beside the register-read step of a five-stage, 32-bit, word-addressed pipeline. It looks at the instruction being decoded, works out which register numbers it reads, and sends those numbers to the register file. It then takes the two values the register file returns and corrects them. A value is replaced whenever a later instruction (in execute, memory or writeback) is about to write the same register. Register 0 always reads zero, so it is never corrected and never causes a wait.

Some results are not ready yet: a load still in execute has not produced its data. When the instruction being decoded needs that data, the unit raises `stall`. While `stall` is high, the fetch and decode buffers keep their contents. The word offered to the execute buffer becomes the all-zero no-operation (an add of register 0 to register 0 into register 0). Each later stage reports its destination register number, its write enable and its result. The memory and writeback stages also report a load flag and the loaded data.

Top module: `opfwd_hazard_unit`

## Requirements
- R1: For a source the decoded instruction reads, if an enabled later stage writes that same nonzero register number, the operand output takes that stage's value; if no stage matches, the operand equals the register-file value.
- R2: When several stages match the same source, the youngest wins: execute over memory, and memory over writeback.
- R3: Register 0 is never forwarded and never raises `stall`; its operand is always the register-file value.
- R4: `stall` is 1 exactly when the execute stage holds a load (`ex_is_load`=1, `ex_wen`=1) whose nonzero destination equals a source register the decoded instruction reads.
- R5: A stage whose write enable is 0 is never used for forwarding, even when its destination number matches.
- R6: When the matching memory or writeback stage carries a load (its load flag = 1), the operand is that stage's loaded data and not its result (address) value.
- R7: `ex_instr_next` equals 32'h0000_0000 while `stall` is 1, and equals `id_instr` otherwise.
- R8: The opcode is `id_instr[31:28]`. `rf_addr_a` is always `id_instr[23:20]`. `rf_addr_b` is `id_instr[3:0]` for opcodes 0 (add) and 1 (nand), and `id_instr[27:24]` for every other opcode.
- R9: Which sources count as read depends on the opcode. Both sources are read for opcodes 0, 1, 4 (store), 8 and 9 (compare branches). Only source a is read for opcodes 2 (add immediate), 3 (load) and 6 (jump and link). Neither is read for opcodes 5, 7, 10 or unlisted ones. A source that is not read is never forwarded and never raises `stall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_instr | input | 32 | Instruction in the decode stage |
| rf_data_a | input | 32 | Register-file value read at `rf_addr_a` |
| rf_data_b | input | 32 | Register-file value read at `rf_addr_b` |
| ex_dst | input | 4 | Destination register of the execute-stage instruction |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| ex_result | input | 32 | Execute-stage ALU result |
| mem_dst | input | 4 | Destination register of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| mem_result | input | 32 | Memory-stage ALU result |
| mem_load_data | input | 32 | Data read from memory in the memory stage |
| wb_dst | input | 4 | Destination register of the writeback-stage instruction |
| wb_wen | input | 1 | Writeback-stage instruction writes a register |
| wb_is_load | input | 1 | Writeback-stage instruction is a load |
| wb_result | input | 32 | Writeback-stage ALU result |
| wb_load_data | input | 32 | Loaded data carried by the writeback stage |
| rf_addr_a | output | 4 | Register-file read address for source a |
| rf_addr_b | output | 4 | Register-file read address for source b |
| opnd_a | output | 32 | Corrected operand for source a |
| opnd_b | output | 32 | Corrected operand for source b |
| stall | output | 1 | Hold earlier buffers and inject a bubble |
| ex_instr_next | output | 32 | Word to load into the execute buffer |

## Verification
The hardest case to reach is the three-way match: all of execute, memory and writeback are enabled, all target the same register, and only the age order decides the winner. The bench therefore drives all three stages together with different values. It then switches off the stages one at a time, youngest first, so that each level of the priority shows up at the operand port. The bench also crosses the load-in-execute condition with opcodes that leave a field unread. This separates a true load-use stall from a spurious match on a field that only looks like a register number.

// File: rtl/fwd_pkg.sv
// Shared opcode encoding and constants for the forwarding/hazard unit.
package fwd_pkg;
    localparam int XLEN  = 32;
    localparam int REG_W = 4;
    localparam int NSTG  = 3;   // execute, memory, writeback (index 0 = youngest)

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0,
        OP_NAND = 4'h1,
        OP_ADDI = 4'h2,
        OP_LW   = 4'h3,
        OP_SW   = 4'h4,
        OP_BR   = 4'h5,
        OP_JALR = 4'h6,
        OP_HALT = 4'h7,
        OP_BLT  = 4'h8,
        OP_BGT  = 4'h9,
        OP_LEA  = 4'hA
    } opcode_e;
endpackage

// File: rtl/fwd_src_decode.sv
// Source-register decoder.
// Maps the decode-stage opcode to the two register-file read addresses and
// flags saying whether each source is really read.
// Assumes the register fields sit at [27:24], [23:20] and [3:0].
module fwd_src_decode
    import fwd_pkg::*;
#(
    parameter int REG_W_P = REG_W
) (
    input  logic [3:0]         opcode,
    input  logic [REG_W_P-1:0] fld_hi,   // bits [27:24]
    input  logic [REG_W_P-1:0] fld_mid,  // bits [23:20]
    input  logic [REG_W_P-1:0] fld_lo,   // bits [3:0]
    output logic [REG_W_P-1:0] src_a,
    output logic [REG_W_P-1:0] src_b,
    output logic               use_a,
    output logic               use_b
);
    // Choose the read fields and usage flags from the opcode.
    always_comb begin
        src_a = fld_mid;
        src_b = fld_hi;
        use_a = 1'b0;
        use_b = 1'b0;
        unique case (opcode)
            OP_ADD, OP_NAND: begin
                src_b = fld_lo;
                use_a = 1'b1;
                use_b = 1'b1;
            end
            OP_SW, OP_BLT, OP_BGT: begin
                use_a = 1'b1;
                use_b = 1'b1;
            end
            OP_ADDI, OP_LW, OP_JALR: begin
                use_a = 1'b1;
            end
            default: begin
                use_a = 1'b0;
                use_b = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/fwd_select.sv
// Per-source forwarding selector.
// Replaces a register-file value with the value of the youngest enabled stage
// whose destination matches the source. Register 0 and unread sources never match.
// Assumes stage index 0 is the youngest.
module fwd_select #(
    parameter int XLEN_P  = 32,
    parameter int REG_W_P = 4,
    parameter int NSTG_P  = 3
) (
    input  logic [REG_W_P-1:0] src,
    input  logic               use_src,
    input  logic [XLEN_P-1:0]  rf_val,
    input  logic [REG_W_P-1:0] stg_dst [NSTG_P],
    input  logic               stg_wen [NSTG_P],
    input  logic [XLEN_P-1:0]  stg_val [NSTG_P],
    output logic [XLEN_P-1:0]  opnd
);
    logic [NSTG_P-1:0] hit;
    logic              src_nonzero;

    assign src_nonzero = (src != '0);

    // One match comparator per later stage.
    for (genvar i = 0; i < NSTG_P; i++) begin : g_match
        assign hit[i] = use_src && src_nonzero && stg_wen[i] && (stg_dst[i] == src);
    end

    // Oldest first, so younger matches overwrite older ones.
    always_comb begin
        opnd = rf_val;
        for (int i = NSTG_P - 1; i >= 0; i--) begin
            if (hit[i]) opnd = stg_val[i];
        end
    end

    // Guard the pass-through cases.
    always_comb begin
        if (hit == '0) begin
            AST_NOHIT_PASSTHRU: assert (opnd == rf_val); // R1
        end
        if (src == '0) begin
            AST_ZERO_REG_PASSTHRU: assert (opnd == rf_val); // R3
        end
    end
endmodule

// File: rtl/fwd_hazard.sv
// Load-use detector.
// Raises stall when a load in execute writes a nonzero register that the
// decode-stage instruction reads.
module fwd_hazard #(
    parameter int REG_W_P = 4
) (
    input  logic [REG_W_P-1:0] src_a,
    input  logic [REG_W_P-1:0] src_b,
    input  logic               use_a,
    input  logic               use_b,
    input  logic [REG_W_P-1:0] ex_dst,
    input  logic               ex_wen,
    input  logic               ex_is_load,
    output logic               stall
);
    logic ld_pending;
    logic dep_a, dep_b;

    // Compare the pending load destination with each read source.
    always_comb begin
        ld_pending = ex_is_load && ex_wen && (ex_dst != '0);
        dep_a      = use_a && (src_a == ex_dst);
        dep_b      = use_b && (src_b == ex_dst);
        stall      = ld_pending && (dep_a || dep_b);
    end

    // A stall always traces back to a nonzero, enabled load.
    always_comb begin
        if (stall) begin
            AST_STALL_NEEDS_LOAD: assert (ex_is_load && ex_wen && (ex_dst != '0)); // R4
        end
    end
endmodule

// File: rtl/opfwd_hazard_unit.sv
// Operand forwarding and load-use hazard unit (top).
// Decodes the source registers of the decode-stage instruction and corrects
// both operands from the execute, memory and writeback stages. Flags load-use
// hazards and offers a no-operation word to the execute buffer while stalled.
// Assumes 32-bit instructions with the opcode in [31:28].
module opfwd_hazard_unit
    import fwd_pkg::*;
#(
    parameter int XLEN_P  = XLEN,
    parameter int REG_W_P = REG_W
) (
    input  logic [31:0]        id_instr,
    input  logic [XLEN_P-1:0]  rf_data_a,
    input  logic [XLEN_P-1:0]  rf_data_b,
    input  logic [REG_W_P-1:0] ex_dst,
    input  logic               ex_wen,
    input  logic               ex_is_load,
    input  logic [XLEN_P-1:0]  ex_result,
    input  logic [REG_W_P-1:0] mem_dst,
    input  logic               mem_wen,
    input  logic               mem_is_load,
    input  logic [XLEN_P-1:0]  mem_result,
    input  logic [XLEN_P-1:0]  mem_load_data,
    input  logic [REG_W_P-1:0] wb_dst,
    input  logic               wb_wen,
    input  logic               wb_is_load,
    input  logic [XLEN_P-1:0]  wb_result,
    input  logic [XLEN_P-1:0]  wb_load_data,
    output logic [REG_W_P-1:0] rf_addr_a,
    output logic [REG_W_P-1:0] rf_addr_b,
    output logic [XLEN_P-1:0]  opnd_a,
    output logic [XLEN_P-1:0]  opnd_b,
    output logic               stall,
    output logic [31:0]        ex_instr_next
);
    localparam int          NSRC     = 2;
    localparam logic [31:0] NOOP_INS = 32'h0000_0000;

    logic [REG_W_P-1:0] src   [NSRC];
    logic               use_s [NSRC];
    logic [XLEN_P-1:0]  rfv   [NSRC];
    logic [XLEN_P-1:0]  opnd  [NSRC];
    logic [REG_W_P-1:0] stg_dst [NSTG];
    logic               stg_wen [NSTG];
    logic [XLEN_P-1:0]  stg_val [NSTG];

    fwd_src_decode #(.REG_W_P(REG_W_P)) u_dec (
        .opcode (id_instr[31:28]),
        .fld_hi (id_instr[27:24]),
        .fld_mid(id_instr[23:20]),
        .fld_lo (id_instr[3:0]),
        .src_a  (src[0]),
        .src_b  (src[1]),
        .use_a  (use_s[0]),
        .use_b  (use_s[1])
    );

    // Gather per-stage candidates; loads supply their memory data.
    always_comb begin
        stg_dst[0] = ex_dst;
        stg_wen[0] = ex_wen;
        stg_val[0] = ex_result;
        stg_dst[1] = mem_dst;
        stg_wen[1] = mem_wen;
        stg_val[1] = mem_is_load ? mem_load_data : mem_result;
        stg_dst[2] = wb_dst;
        stg_wen[2] = wb_wen;
        stg_val[2] = wb_is_load ? wb_load_data : wb_result;
        rfv[0]     = rf_data_a;
        rfv[1]     = rf_data_b;
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        fwd_select #(
            .XLEN_P (XLEN_P),
            .REG_W_P(REG_W_P),
            .NSTG_P (NSTG)
        ) u_sel (
            .src    (src[s]),
            .use_src(use_s[s]),
            .rf_val (rfv[s]),
            .stg_dst(stg_dst),
            .stg_wen(stg_wen),
            .stg_val(stg_val),
            .opnd   (opnd[s])
        );
    end

    fwd_hazard #(.REG_W_P(REG_W_P)) u_haz (
        .src_a     (src[0]),
        .src_b     (src[1]),
        .use_a     (use_s[0]),
        .use_b     (use_s[1]),
        .ex_dst    (ex_dst),
        .ex_wen    (ex_wen),
        .ex_is_load(ex_is_load),
        .stall     (stall)
    );

    // Drive outward-facing addresses, operands and the execute-buffer word.
    always_comb begin
        rf_addr_a     = src[0];
        rf_addr_b     = src[1];
        opnd_a        = opnd[0];
        opnd_b        = opnd[1];
        ex_instr_next = stall ? NOOP_INS : id_instr;
    end

    // Port-level checks across the decoder and the hazard detector.
    always_comb begin
        if (stall) begin
            AST_STALL_MATCHES_SRC: assert ((ex_dst == rf_addr_a) || (ex_dst == rf_addr_b)); // R4
        end
        if (id_instr[31:28] == 4'h5 || id_instr[31:28] == 4'h7 || id_instr[31:28] == 4'hA) begin
            AST_NOREAD_NO_STALL: assert (!stall); // R9
        end
        if (!stall) begin
            AST_PASS_INSTR: assert (ex_instr_next == id_instr); // R7
        end
    end
endmodule

// File: tb/opfwd_hazard_unit_bench.sv
// Directed bench for the forwarding and hazard unit; one task per scenario.
module opfwd_hazard_unit_bench;
    logic        clk = 1'b0;
    logic [31:0] id_instr, rf_data_a, rf_data_b;
    logic [3:0]  ex_dst, mem_dst, wb_dst;
    logic        ex_wen, ex_is_load, mem_wen, mem_is_load, wb_wen, wb_is_load;
    logic [31:0] ex_result, mem_result, mem_load_data, wb_result, wb_load_data;
    logic [3:0]  rf_addr_a, rf_addr_b;
    logic [31:0] opnd_a, opnd_b, ex_instr_next;
    logic        stall;
    int          n_chk = 0;
    int          n_fail = 0;

    always #5 clk = ~clk;

    opfwd_hazard_unit u_opfwd_hazard_unit (
        .id_instr(id_instr), .rf_data_a(rf_data_a), .rf_data_b(rf_data_b),
        .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_is_load(ex_is_load), .ex_result(ex_result),
        .mem_dst(mem_dst), .mem_wen(mem_wen), .mem_is_load(mem_is_load),
        .mem_result(mem_result), .mem_load_data(mem_load_data),
        .wb_dst(wb_dst), .wb_wen(wb_wen), .wb_is_load(wb_is_load),
        .wb_result(wb_result), .wb_load_data(wb_load_data),
        .rf_addr_a(rf_addr_a), .rf_addr_b(rf_addr_b),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .stall(stall), .ex_instr_next(ex_instr_next)
    );

    function automatic logic [31:0] mk(input logic [3:0] op, input logic [3:0] hi,
                                       input logic [3:0] mid, input logic [3:0] lo);
        return {op, hi, mid, 16'h0000, lo};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic clear_all();
        @(negedge clk);
        id_instr = 32'h0; rf_data_a = 32'h0; rf_data_b = 32'h0;
        ex_dst = 4'h0; ex_wen = 1'b0; ex_is_load = 1'b0; ex_result = 32'h0;
        mem_dst = 4'h0; mem_wen = 1'b0; mem_is_load = 1'b0; mem_result = 32'h0; mem_load_data = 32'h0;
        wb_dst = 4'h0; wb_wen = 1'b0; wb_is_load = 1'b0; wb_result = 32'h0; wb_load_data = 32'h0;
    endtask

    task automatic settle();
        #2;
    endtask

    task automatic t_reset_state();
        clear_all(); settle();
        chk("R7 idle stall", {31'h0, stall}, 32'h0);
        chk("R1 idle opnd_a", opnd_a, 32'h0);
        chk("R7 idle pass", ex_instr_next, 32'h0);
    endtask

    task automatic t_decode_fields();
        clear_all();
        id_instr = mk(4'h0, 4'h3, 4'h5, 4'h9); settle();
        chk("R8 add addr_a", {28'h0, rf_addr_a}, 32'h5);
        chk("R8 add addr_b", {28'h0, rf_addr_b}, 32'h9);
        id_instr = mk(4'h8, 4'h3, 4'h5, 4'h9); settle();
        chk("R8 blt addr_a", {28'h0, rf_addr_a}, 32'h5);
        chk("R8 blt addr_b", {28'h0, rf_addr_b}, 32'h3);
        id_instr = mk(4'h4, 4'hC, 4'h2, 4'h1); settle();
        chk("R8 sw addr_b", {28'h0, rf_addr_b}, 32'hC);
    endtask

    task automatic t_single_stage();
        clear_all();
        id_instr = mk(4'h0, 4'h1, 4'h6, 4'h7);
        rf_data_a = 32'hAAAA_0000; rf_data_b = 32'hBBBB_0000;
        ex_dst = 4'h6; ex_wen = 1'b1; ex_result = 32'h1111_1111; settle();
        chk("R1 ex fwd a", opnd_a, 32'h1111_1111);
        chk("R1 b untouched", opnd_b, 32'hBBBB_0000);
        ex_wen = 1'b0; mem_dst = 4'h7; mem_wen = 1'b1; mem_result = 32'h2222_2222; settle();
        chk("R1 mem fwd b", opnd_b, 32'h2222_2222);
        mem_wen = 1'b0; wb_dst = 4'h7; wb_wen = 1'b1; wb_result = 32'h3333_3333; settle();
        chk("R1 wb fwd b", opnd_b, 32'h3333_3333);
        chk("R1 a untouched", opnd_a, 32'hAAAA_0000);
    endtask

    task automatic t_priority();
        clear_all();
        id_instr = mk(4'h2, 4'h1, 4'h4, 4'h0); rf_data_a = 32'h0BAD_0BAD;
        ex_dst = 4'h4; ex_wen = 1'b1; ex_result = 32'hE0E0_E0E0;
        mem_dst = 4'h4; mem_wen = 1'b1; mem_result = 32'hD0D0_D0D0;
        wb_dst = 4'h4; wb_wen = 1'b1; wb_result = 32'hC0C0_C0C0; settle();
        chk("R2 ex wins", opnd_a, 32'hE0E0_E0E0);
        ex_wen = 1'b0; settle();
        chk("R2 mem over wb", opnd_a, 32'hD0D0_D0D0);
        mem_wen = 1'b0; settle();
        chk("R2 wb last", opnd_a, 32'hC0C0_C0C0);
    endtask

    task automatic t_zero_reg();
        clear_all();
        id_instr = mk(4'h0, 4'h2, 4'h0, 4'h0); rf_data_a = 32'h0; rf_data_b = 32'h0;
        ex_dst = 4'h0; ex_wen = 1'b1; ex_is_load = 1'b1; ex_result = 32'h5555_5555;
        mem_dst = 4'h0; mem_wen = 1'b1; mem_result = 32'h6666_6666; settle();
        chk("R3 zero opnd_a", opnd_a, 32'h0);
        chk("R3 zero opnd_b", opnd_b, 32'h0);
        chk("R3 zero no stall", {31'h0, stall}, 32'h0);
    endtask

    task automatic t_load_use();
        clear_all();
        id_instr = mk(4'h2, 4'h6, 4'h6, 4'h0);
        ex_dst = 4'h6; ex_wen = 1'b1; ex_is_load = 1'b1; settle();
        chk("R4 load-use stall", {31'h0, stall}, 32'h1);
        chk("R7 bubble word", ex_instr_next, 32'h0);
        id_instr = mk(4'h4, 4'h6, 4'h2, 4'h0); settle();
        chk("R4 store data src stall", {31'h0, stall}, 32'h1);
        ex_is_load = 1'b0; settle();
        chk("R4 non-load no stall", {31'h0, stall}, 32'h0);
        chk("R7 pass when clear", ex_instr_next, mk(4'h4, 4'h6, 4'h2, 4'h0));
        ex_is_load = 1'b1; ex_dst = 4'h9; settle();
        chk("R4 other dst no stall", {31'h0, stall}, 32'h0);
    endtask

    task automatic t_wen_off();
        clear_all();
        id_instr = mk(4'h1, 4'h1, 4'h8, 4'h8);
        rf_data_a = 32'h1234_5678; rf_data_b = 32'h1234_5678;
        ex_dst = 4'h8; ex_result = 32'hFFFF_0000;
        mem_dst = 4'h8; mem_result = 32'hFFFF_1111;
        wb_dst = 4'h8; wb_result = 32'hFFFF_2222; settle();
        chk("R5 disabled a", opnd_a, 32'h1234_5678);
        chk("R5 disabled b", opnd_b, 32'h1234_5678);
    endtask

    task automatic t_load_data();
        clear_all();
        id_instr = mk(4'h3, 4'h2, 4'hB, 4'h0); rf_data_a = 32'h0;
        mem_dst = 4'hB; mem_wen = 1'b1; mem_is_load = 1'b1;
        mem_result = 32'h0000_0040; mem_load_data = 32'hCAFE_F00D; settle();
        chk("R6 mem load data", opnd_a, 32'hCAFE_F00D);
        mem_wen = 1'b0;
        wb_dst = 4'hB; wb_wen = 1'b1; wb_is_load = 1'b1;
        wb_result = 32'h0000_0041; wb_load_data = 32'hBEEF_0001; settle();
        chk("R6 wb load data", opnd_a, 32'hBEEF_0001);
    endtask

    task automatic t_unused_src();
        clear_all();
        id_instr = mk(4'h5, 4'h3, 4'h3, 4'h3);
        rf_data_a = 32'h0A0A_0A0A; rf_data_b = 32'h0B0B_0B0B;
        ex_dst = 4'h3; ex_wen = 1'b1; ex_is_load = 1'b1; ex_result = 32'h7777_7777; settle();
        chk("R9 br no stall", {31'h0, stall}, 32'h0);
        chk("R9 br opnd_a", opnd_a, 32'h0A0A_0A0A);
        id_instr = mk(4'hA, 4'h3, 4'h3, 4'h3); settle();
        chk("R9 lea no stall", {31'h0, stall}, 32'h0);
        ex_is_load = 1'b0;
        id_instr = mk(4'h6, 4'h3, 4'h5, 4'h0); settle();
        chk("R9 jalr b not read", opnd_b, 32'h0B0B_0B0B);
        id_instr = mk(4'h2, 4'h3, 4'h5, 4'h3); settle();
        chk("R9 addi b not read", opnd_b, 32'h0B0B_0B0B);
    endtask

    initial begin
        fork
            begin
                t_reset_state();
                t_decode_fields();
                t_single_stage();
                t_priority();
                t_zero_reg();
                t_load_use();
                t_wen_off();
                t_load_data();
                t_unused_src();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule